// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block holds the configuration of an interrupt router and exposes it to a processor through just two word addresses. A write to the select word picks an internal register; the data window word then reads or writes that register. The internal space holds a version word, an identification word (also visible through a second, read-only arbitration word) and a routing table with one 64-bit entry per interrupt input. Each entry is reached as two 32-bit halves.

The router's delivery logic sits outside. It receives the whole table on a flat output bus, a one-cycle pulse per input whenever that input's mask bit is flipped by software, and a one-cycle pulse whenever any entry is written. It reports back through per-input pulses that set or clear the "awaiting end-of-interrupt" flag and a per-input busy level that becomes the delivery-status flag. Software writes never alter these two flags, except that an entry configured as edge-triggered can never hold the awaiting flag.

Top module: `irq_route_regs`

## Requirements
- R1: Offset 0x00 is the select word. A write stores only bits 7:0 of the data; a read returns the stored select in bits 7:0 and zero above.
- R2: Select 0x01 is the version word and reads {8'h00, NPINS-1, 8'h00, VERSION}; writes to it change nothing.
- R3: Select 0x00 is the ID word: a write stores data bits 27:24, a read returns them in bits 27:24 with all other bits zero. Select 0x02 reads the same value and ignores writes.
- R4: For select S >= 0x10 the table entry is (S-0x10)>>1; an even S reaches entry bits 31:0, an odd S bits 63:32. Entry layout: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], awaiting-EOI [14], trigger [15] (1 = level, 0 = edge), mask [16], destination [63:56].
- R5: A window read at an entry index of NPINS or more returns 32'hFFFFFFFF; a write there changes no entry and raises no pulse.
- R6: A window write replaces only the addressed 32-bit half of the entry.
- R7: Bits 12 and 14 ignore window writes. Bit 12 equals busy_in of that pin one cycle earlier; bit 14 is set by rirr_set only while the entry is level-triggered and cleared by rirr_clr.
- R8: After any window write to an entry whose resulting trigger bit is 0, bit 14 of that entry is 0.
- R9: mask_chg[i] is high for exactly the cycle after a write that flips the mask bit of entry i, and stays low when the written mask equals the old one.
- R10: tbl_chg is high for the cycle after every in-range table write, whether or not the value changed.
- R11: Reset clears the select and ID and every entry bit except the mask bit, which it sets.
- R12: Offsets other than 0x00 and 0x10 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Word offset of the access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| rirr_set | input | NPINS | Per-pin pulse: mark entry awaiting end-of-interrupt |
| rirr_clr | input | NPINS | Per-pin pulse: end-of-interrupt received |
| busy_in | input | NPINS | Per-pin delivery-in-progress level |
| tbl_entries | output | 64*NPINS | All entries, entry i at bits 64*i+63 : 64*i |
| mask_chg | output | NPINS | Per-pin pulse on mask flip |
| tbl_chg | output | 1 | Pulse on any table write |

## Verification
The bench writes data with bits 12 and 14 set and cleared to show the status flags survive; a design that stored them blindly would report a spurious or lost pending end-of-interrupt. It switches a level entry with the awaiting flag set to edge, and a design missing the forced clear would leave that input blocked forever. Indices just past the last pin and at the top of the select range are read and written, where a bad bound would alias onto a real entry. Rewriting the same mask value checks that a design pulsing on every write rather than on a flip would not flood the delivery side.

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int NPINS = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          reg_addr,
  input  logic                reg_we,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NPINS-1:0]    rirr_set,
  input  logic [NPINS-1:0]    rirr_clr,
  input  logic [NPINS-1:0]    busy_in,
  output logic [64*NPINS-1:0] tbl_entries,
  output logic [NPINS-1:0]    mask_chg,
  output logic                tbl_chg
);
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] TBL_BASE = 8'h10;
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [7:0] LAST_PIN = 8'(NPINS - 1);

  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  logic [63:0] ent_q [NPINS];

  logic [7:0]  sel_off;
  logic [6:0]  idx_full;
  logic        in_tbl;
  logic        wr_win;
  logic        wr_tbl;
  logic [IW-1:0] idx;
  logic [63:0] rd_ent;
  logic [31:0] win_rd;

  assign sel_off  = sel_q - TBL_BASE;
  assign idx_full = sel_off[7:1];
  assign in_tbl   = (sel_q >= TBL_BASE) && ({1'b0, idx_full} <= LAST_PIN);
  assign idx      = idx_full[IW-1:0];
  assign wr_win   = reg_we && (reg_addr == OFS_WIN);
  assign wr_tbl   = wr_win && in_tbl;
  assign rd_ent   = in_tbl ? ent_q[idx] : '1;

  always_comb begin
    case (sel_q)
      SEL_ID, SEL_ARB: win_rd = {4'h0, id_q, 24'h0};
      SEL_VER:         win_rd = {8'h00, LAST_PIN, 8'h00, VERSION};
      default:         win_rd = (sel_q >= TBL_BASE) ?
                                (sel_q[0] ? rd_ent[63:32] : rd_ent[31:0]) : 32'h0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      OFS_SEL: reg_rdata = {24'h0, sel_q};
      OFS_WIN: reg_rdata = win_rd;
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      id_q    <= '0;
      tbl_chg <= 1'b0;
    end else begin
      tbl_chg <= wr_tbl;
      if (reg_we && reg_addr == OFS_SEL) sel_q <= reg_wdata[7:0];
      if (wr_win && sel_q == SEL_ID) id_q <= reg_wdata[27:24];
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_ent
    logic wr_lo, wr_hi;
    logic [63:0] nxt;

    assign wr_lo = wr_tbl && (idx == IW'(i)) && !sel_q[0];
    assign wr_hi = wr_tbl && (idx == IW'(i)) &&  sel_q[0];

    always_comb begin
      nxt = ent_q[i];
      if (wr_lo) nxt[31:0]  = reg_wdata;
      if (wr_hi) nxt[63:32] = reg_wdata;
      nxt[12] = busy_in[i];
      nxt[14] = ent_q[i][14];
      if (rirr_clr[i])               nxt[14] = 1'b0;
      else if (rirr_set[i] && nxt[15]) nxt[14] = 1'b1;
      if ((wr_lo || wr_hi) && !nxt[15]) nxt[14] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[i]    <= 64'h0000_0000_0001_0000;
        mask_chg[i] <= 1'b0;
      end else begin
        ent_q[i]    <= nxt;
        mask_chg[i] <= wr_lo && (reg_wdata[16] != ent_q[i][16]);
      end
    end

    assign tbl_entries[64*i +: 64] = ent_q[i];
  end
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int NPINS = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          reg_addr,
  input logic                reg_we,
  input logic [31:0]         reg_wdata,
  input logic [31:0]         reg_rdata,
  input logic [NPINS-1:0]    busy_in,
  input logic [64*NPINS-1:0] tbl_entries,
  input logic [NPINS-1:0]    mask_chg,
  input logic                tbl_chg,
  input logic [7:0]          sel_q
);
  logic [7:0] ck_idx;
  logic       ck_tbl_sel;
  assign ck_idx     = {1'b0, sel_q[7:1]} - 8'h08;
  assign ck_tbl_sel = sel_q >= 8'h10;

  a_r1_sel_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 8'h00 |=> sel_q == $past(reg_wdata[7:0]));

  a_r2_version_word: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 8'h10 && sel_q == 8'h01 |->
      reg_rdata == {8'h00, 8'(NPINS - 1), 8'h00, VERSION});

  a_r10_tbl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 8'h10 && ck_tbl_sel && ck_idx < 8'(NPINS) |=> tbl_chg);

  a_r5_oor_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 8'h10 && ck_tbl_sel && ck_idx >= 8'(NPINS) |=> !tbl_chg);

  a_r9_one_mask_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_chg));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    a_r8_edge_no_rirr: assert property (@(posedge clk) disable iff (!rst_n)
      !tbl_entries[64*i+15] |-> !tbl_entries[64*i+14]);
    a_r7_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> tbl_entries[64*i+12] == $past(busy_in[i]));
  end
endmodule

bind irq_route_regs irq_route_regs_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (.*);

// File: tb/test_irq_route_regs.sv
module test_irq_route_regs;
  localparam int NPINS = 24;
  localparam logic [7:0] VER = 8'h11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NPINS-1:0] rirr_set = '0, rirr_clr = '0, busy_in = '0;
  logic [64*NPINS-1:0] tbl_entries;
  logic [NPINS-1:0] mask_chg;
  logic tbl_chg;
  int checks = 0, fails = 0;

  irq_route_regs #(.NPINS(NPINS), .VERSION(VER)) i_irq_route_regs (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_sel(logic [7:0] s, output logic [31:0] d);
    wr(8'h00, {24'h0, s});
    rd(8'h10, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d);          chk("R11 select", d, 0);
    rd_sel(8'h16, d);      chk("R11 entry3 lo", d, 32'h0001_0000);
    rd_sel(8'h17, d);      chk("R11 entry3 hi", d, 0);
    rd_sel(8'h00, d);      chk("R11 id", d, 0);
  endtask

  task automatic t_select;
    logic [31:0] d;
    wr(8'h00, 32'hDEAD_C1A5);
    rd(8'h00, d);          chk("R1 low byte", d, 32'hA5);
  endtask

  task automatic t_version;
    logic [31:0] d;
    rd_sel(8'h01, d);      chk("R2 version", d, {8'h00, 8'd23, 8'h00, VER});
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d);          chk("R2 write ignored", d, {8'h00, 8'd23, 8'h00, VER});
  endtask

  task automatic t_id;
    logic [31:0] d;
    wr(8'h00, 32'h0);
    wr(8'h10, 32'hF5FF_FFFF);
    rd(8'h10, d);          chk("R3 id", d, 32'h0500_0000);
    rd_sel(8'h02, d);      chk("R3 arb", d, 32'h0500_0000);
    wr(8'h10, 32'h0A00_0000);
    rd_sel(8'h00, d);      chk("R3 arb write ignored", d, 32'h0500_0000);
  endtask

  task automatic t_table;
    logic [31:0] d;
    wr(8'h00, 32'h16);
    wr(8'h10, 32'h0000_D0AB);   // level, unmasked, bits 12/14 set in data
    chk("R10 pulse", tbl_chg, 1);
    chk("R9 unmask pulse", mask_chg, 24'h000008);
    rd(8'h10, d);          chk("R7 status bits kept", d, 32'h0000_80AB);
    chk("R4 vector field", tbl_entries[64*3 +: 8], 8'hAB);
    wr(8'h00, 32'h17);
    wr(8'h10, 32'hCD00_0000);
    chk("R9 no pulse hi", mask_chg, 0);
    chk("R4 dest field", tbl_entries[64*3+56 +: 8], 8'hCD);
    rd_sel(8'h16, d);      chk("R6 lo kept", d, 32'h0000_80AB);
    wr(8'h10, 32'h0000_80AB);
    chk("R9 same mask no pulse", mask_chg, 0);
    chk("R10 pulse same value", tbl_chg, 1);
    rd_sel(8'h17, d);      chk("R6 hi kept", d, 32'hCD00_0000);
  endtask

  task automatic t_status;
    logic [31:0] d;
    @(negedge clk); rirr_set[3] = 1'b1; busy_in[3] = 1'b1;
    @(negedge clk); rirr_set[3] = 1'b0;
    rd_sel(8'h16, d);      chk("R7 set level+busy", d, 32'h0000_D0AB);
    wr(8'h10, 32'h0000_80AB);
    rd(8'h10, d);          chk("R7 flags survive write", d, 32'h0000_D0AB);
    @(negedge clk); rirr_clr[3] = 1'b1; busy_in[3] = 1'b0;
    @(negedge clk); rirr_clr[3] = 1'b0;
    rd(8'h10, d);          chk("R7 cleared", d, 32'h0000_80AB);
    @(negedge clk); rirr_set[3] = 1'b1;
    @(negedge clk); rirr_set[3] = 1'b0;
    wr(8'h10, 32'h0000_00AB);   // switch to edge
    rd(8'h10, d);          chk("R8 edge clears flag", d, 32'h0000_00AB);
    @(negedge clk); rirr_set[3] = 1'b1;
    @(negedge clk); rirr_set[3] = 1'b0;
    rd(8'h10, d);          chk("R7 set ignored on edge", d, 32'h0000_00AB);
    wr(8'h10, 32'h0001_00AB);
    chk("R9 mask set pulse", mask_chg, 24'h000008);
  endtask

  task automatic t_range;
    logic [31:0] d;
    rd_sel(8'h40, d);      chk("R5 read lo oor", d, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0);
    chk("R5 no pulse", tbl_chg, 0);
    rd_sel(8'hFF, d);      chk("R5 read top", d, 32'hFFFF_FFFF);
    rd_sel(8'h3E, d);      chk("R5 last entry lo", d, 32'h0001_0000);
    chk("R5 last entry intact", tbl_entries[64*23 +: 64], 64'h0000_0000_0001_0000);
  endtask

  task automatic t_other_ofs;
    logic [31:0] d;
    wr(8'h00, 32'h16);
    rd(8'h04, d);          chk("R12 read zero", d, 0);
    wr(8'h04, 32'h0000_0020);
    wr(8'h20, 32'h0000_0021);
    rd(8'h00, d);          chk("R12 no write", d, 32'h16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_version();
    t_id();
    t_table();
    t_status();
    t_range();
    t_other_ofs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule